// File: doc/BRIEF.md
# Piano Keyboard Raster Renderer

This block drives a raster monitor at 640 by 480 and paints a row of piano keys on it. A 50 MHz system clock is split into a pixel tick on every second cycle. Two counters walk the frame, and each pixel position is tested against a set of fixed rectangles, one per key. No image is stored anywhere.

White keys are filled white with a black outline. Black keys sit on top of the gaps between white keys, in the usual two-then-three grouping. A controller that knows which note is sounding sends a key index with a one-cycle valid strobe. That key is then painted red until a clear or an invalid index arrives. A new request is held as pending and only becomes visible at the start of vertical sync, so a frame that is already being scanned never shows a half-changed keyboard.

Every colour channel is one bit wide and both sync outputs are active low. The whole geometry is set by parameters: the porch and pulse lengths, the keyboard origin, the key sizes and the number of white keys.

Top module: `piano_vga_top`

## Requirements
- R1: A line lasts H_ACTIVE+H_FRONT+H_PULSE+H_BACK pixels, and `hsync_n` is 0 for exactly H_PULSE pixels, starting at pixel H_ACTIVE+H_FRONT of the line.
- R2: A frame lasts V_ACTIVE+V_FRONT+V_PULSE+V_BACK lines, and `vsync_n` is 0 on exactly V_PULSE lines, starting at line V_ACTIVE+V_FRONT.
- R3: During reset, `hsync_n`=`vsync_n`=1 and RGB=000. A new pixel is produced every second clock: pixel k of the scan after reset release (k = line*line_length + column, counting on through later frames) is valid at the outputs from rising edge 2k+2 until edge 2k+4.
- R4: RGB ({red,green,blue}) is 000 on every pixel with column >= H_ACTIVE or line >= V_ACTIVE.
- R5: Inside the active window, a pixel that falls on no key is 000.
- R6: White key i covers columns KB_X+i*WHITE_W to KB_X+(i+1)*WHITE_W-1 and lines KB_Y to KB_Y+WHITE_H-1. Its body is 111. The outline is 000 and covers the first column of every white key, the last column of the keyboard, and its top and bottom lines.
- R7: Black key slot j (0 <= j <= NUM_WHITE-2) exists only when j mod 7 is neither 2 nor 6. It starts at column KB_X+(j+1)*WHITE_W-BLACK_W/2, is BLACK_W wide, covers lines KB_Y to KB_Y+BLACK_H-1, is 000, and is drawn over the white keys.
- R8: A highlighted white key has its body painted 100, and its outline stays 000. A highlighted black key is 100 over its whole area.
- R9: Key index values below NUM_WHITE select white key `key_idx`. A value NUM_WHITE+j selects black slot j. Any other value, or a slot that does not exist, clears the highlight when it is strobed.
- R10: `key_clear` removes the highlight, and it wins over `key_valid` in the same cycle.
- R11: A request made while a frame is being scanned does not change that frame. It takes effect from the first line of vertical sync onward, so the next active frame shows it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, twice the pixel rate |
| rst | input | 1 | Synchronous active-high reset |
| key_valid | input | 1 | One-cycle strobe for `key_idx` |
| key_idx | input | KEY_W ($clog2(2*NUM_WHITE), 5 by default) | Key to highlight |
| key_clear | input | 1 | Removes the highlight |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| red | output | 1 | Red channel |
| green | output | 1 | Green channel |
| blue | output | 1 | Blue channel |

## Verification
The sync outputs and the colour of scan pixel k are all registered together on rising edge 2k+2 after reset release. The bench therefore counts rising edges from the release and compares every pixel at the falling edge that follows each even count. A highlight request affects nothing until the first vertical-sync line of the current frame. The bench issues its requests on an active line, checks that the rest of that frame still matches the old state, and expects the new colours in the following frame. The bench runs over a reduced raster of 48 by 24, so each frame is checked pixel by pixel. It covers white keys, present and missing black slots, out-of-range indices, a clear, and a clear that coincides with a valid strobe.

// File: rtl/piano_vga_pkg.sv
package piano_vga_pkg;

    localparam int COORD_W = 11;
    typedef logic [COORD_W-1:0] coord_t;

    typedef struct packed {
        logic r;
        logic g;
        logic b;
    } rgb_t;

    localparam rgb_t C_BLACK = '{r: 1'b0, g: 1'b0, b: 1'b0};
    localparam rgb_t C_WHITE = '{r: 1'b1, g: 1'b1, b: 1'b1};
    localparam rgb_t C_RED   = '{r: 1'b1, g: 1'b0, b: 1'b0};

    // Position and sync state of the pixel the counters point at
    typedef struct packed {
        coord_t x;
        coord_t y;
        logic   active;
        logic   hs_n;
        logic   vs_n;
        logic   frame_start;
    } scan_t;

    // A black key sits in gap j unless the gap is E-F or B-C of an octave
    function automatic logic black_slot_exists(input int j);
        return (j % 7 != 2) && (j % 7 != 6);
    endfunction

endpackage

// File: rtl/vga_scan.sv
module vga_scan
    import piano_vga_pkg::*;
#(
    parameter int H_ACTIVE = 640,
    parameter int H_FRONT  = 16,
    parameter int H_PULSE  = 96,
    parameter int H_BACK   = 48,
    parameter int V_ACTIVE = 480,
    parameter int V_FRONT  = 10,
    parameter int V_PULSE  = 2,
    parameter int V_BACK   = 33
) (
    input  logic  clk,
    input  logic  rst,
    output logic  pix_en,
    output scan_t scan
);
    localparam int H_TOTAL = H_ACTIVE + H_FRONT + H_PULSE + H_BACK;
    localparam int V_TOTAL = V_ACTIVE + V_FRONT + V_PULSE + V_BACK;
    localparam coord_t H_LAST   = coord_t'(H_TOTAL - 1);
    localparam coord_t V_LAST   = coord_t'(V_TOTAL - 1);
    localparam coord_t H_VIS    = coord_t'(H_ACTIVE);
    localparam coord_t V_VIS    = coord_t'(V_ACTIVE);
    localparam coord_t HS_BEGIN = coord_t'(H_ACTIVE + H_FRONT);
    localparam coord_t HS_END   = coord_t'(H_ACTIVE + H_FRONT + H_PULSE);
    localparam coord_t VS_BEGIN = coord_t'(V_ACTIVE + V_FRONT);
    localparam coord_t VS_END   = coord_t'(V_ACTIVE + V_FRONT + V_PULSE);

    logic   tick;
    coord_t hcnt;
    coord_t vcnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            tick <= 1'b0;
            hcnt <= '0;
            vcnt <= '0;
        end else begin
            tick <= ~tick;
            if (tick) begin
                if (hcnt == H_LAST) begin
                    hcnt <= '0;
                    vcnt <= (vcnt == V_LAST) ? '0 : vcnt + 1'b1;
                end else begin
                    hcnt <= hcnt + 1'b1;
                end
            end
        end
    end

    assign pix_en = tick;

    always_comb begin
        scan.x           = hcnt;
        scan.y           = vcnt;
        scan.active      = (hcnt < H_VIS) && (vcnt < V_VIS);
        scan.hs_n        = !((hcnt >= HS_BEGIN) && (hcnt < HS_END));
        scan.vs_n        = !((vcnt >= VS_BEGIN) && (vcnt < VS_END));
        scan.frame_start = (hcnt == '0) && (vcnt == VS_BEGIN);
    end

    p_tick_alternates_r3: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
    p_hold_between_ticks_r3: assert property (@(posedge clk) disable iff (rst)
        !tick |=> ($stable(hcnt) && $stable(vcnt)));
    p_line_wrap_r1: assert property (@(posedge clk) disable iff (rst)
        (tick && hcnt == H_LAST) |=> (hcnt == '0));
    p_line_step_r1: assert property (@(posedge clk) disable iff (rst)
        (tick && hcnt != H_LAST) |=> (hcnt == $past(hcnt) + 1'b1));
    p_line_bound_r1: assert property (@(posedge clk) disable iff (rst)
        hcnt <= H_LAST);
    p_frame_bound_r2: assert property (@(posedge clk) disable iff (rst)
        vcnt <= V_LAST);
    p_vert_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (tick && hcnt != H_LAST) |=> $stable(vcnt));

endmodule

// File: rtl/key_select.sv
module key_select
    import piano_vga_pkg::*;
#(
    parameter int NUM_WHITE = 14,
    parameter int KEY_W     = 5
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 key_valid,
    input  logic [KEY_W-1:0]     key_idx,
    input  logic                 key_clear,
    input  logic                 frame_load,
    output logic [NUM_WHITE-1:0] white_hl,
    output logic [NUM_WHITE-2:0] black_hl
);
    localparam int NUM_SLOTS = NUM_WHITE - 1;

    logic             req_ok;
    logic             pend_vld;
    logic [KEY_W-1:0] pend_idx;
    logic             act_vld;
    logic [KEY_W-1:0] act_idx;

    // Index check: white range, or a black slot that exists
    always_comb begin
        req_ok = 1'b0;
        for (int i = 0; i < NUM_WHITE; i++) begin
            if (key_idx == KEY_W'(i)) req_ok = 1'b1;
        end
        for (int j = 0; j < NUM_SLOTS; j++) begin
            if (black_slot_exists(j) && key_idx == KEY_W'(NUM_WHITE + j)) req_ok = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_vld <= 1'b0;
            pend_idx <= '0;
            act_vld  <= 1'b0;
            act_idx  <= '0;
        end else begin
            if (key_clear) begin
                pend_vld <= 1'b0;
            end else if (key_valid) begin
                pend_vld <= req_ok;
                pend_idx <= key_idx;
            end
            if (frame_load) begin
                act_vld <= pend_vld;
                act_idx <= pend_idx;
            end
        end
    end

    for (genvar i = 0; i < NUM_WHITE; i++) begin : g_white_dec
        assign white_hl[i] = act_vld && (act_idx == KEY_W'(i));
    end

    for (genvar j = 0; j < NUM_SLOTS; j++) begin : g_black_dec
        if (black_slot_exists(j)) begin : g_present
            assign black_hl[j] = act_vld && (act_idx == KEY_W'(NUM_WHITE + j));
        end else begin : g_absent
            assign black_hl[j] = 1'b0;
        end
    end

    p_clear_wins_r10: assert property (@(posedge clk) disable iff (rst)
        key_clear |=> !pend_vld);
    p_no_tearing_r11: assert property (@(posedge clk) disable iff (rst)
        !frame_load |=> ($stable(act_vld) && $stable(act_idx)));
    p_frame_load_r11: assert property (@(posedge clk) disable iff (rst)
        frame_load |=> (act_vld == $past(pend_vld)));
    p_single_key_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({white_hl, black_hl}));
    p_active_decodes_r9: assert property (@(posedge clk) disable iff (rst)
        act_vld |-> ($countones({white_hl, black_hl}) == 1));

endmodule

// File: rtl/key_painter.sv
module key_painter
    import piano_vga_pkg::*;
#(
    parameter int NUM_WHITE = 14,
    parameter int KB_X      = 40,
    parameter int KB_Y      = 300,
    parameter int WHITE_W   = 40,
    parameter int WHITE_H   = 160,
    parameter int BLACK_W   = 24,
    parameter int BLACK_H   = 100
) (
    input  logic                 clk,
    input  logic                 rst,
    input  coord_t               px,
    input  coord_t               py,
    input  logic                 active,
    input  logic [NUM_WHITE-1:0] white_hl,
    input  logic [NUM_WHITE-2:0] black_hl,
    output rgb_t                 color
);
    localparam int     NUM_SLOTS = NUM_WHITE - 1;
    localparam coord_t TOP       = coord_t'(KB_Y);
    localparam coord_t W_BOTTOM  = coord_t'(KB_Y + WHITE_H - 1);
    localparam coord_t B_END_Y   = coord_t'(KB_Y + BLACK_H);
    localparam coord_t W_END_Y   = coord_t'(KB_Y + WHITE_H);
    localparam coord_t RIGHT_COL = coord_t'(KB_X + NUM_WHITE * WHITE_W - 1);

    logic [NUM_WHITE-1:0] hit_w;
    logic [NUM_WHITE-1:0] left_w;
    logic [NUM_SLOTS-1:0] hit_b;
    logic                 in_w_rows;
    logic                 in_b_rows;
    logic                 outline;

    assign in_w_rows = (py >= TOP) && (py < W_END_Y);
    assign in_b_rows = (py >= TOP) && (py < B_END_Y);

    for (genvar i = 0; i < NUM_WHITE; i++) begin : g_white
        localparam coord_t L = coord_t'(KB_X + i * WHITE_W);
        localparam coord_t R = coord_t'(KB_X + (i + 1) * WHITE_W);
        assign hit_w[i]  = in_w_rows && (px >= L) && (px < R);
        assign left_w[i] = (px == L);
    end

    for (genvar j = 0; j < NUM_SLOTS; j++) begin : g_black
        if (black_slot_exists(j)) begin : g_present
            localparam coord_t L = coord_t'(KB_X + (j + 1) * WHITE_W - BLACK_W / 2);
            localparam coord_t R = coord_t'(KB_X + (j + 1) * WHITE_W - BLACK_W / 2 + BLACK_W);
            assign hit_b[j] = in_b_rows && (px >= L) && (px < R);
        end else begin : g_absent
            assign hit_b[j] = 1'b0;
        end
    end

    assign outline = (|(hit_w & left_w)) || (px == RIGHT_COL) || (py == TOP) || (py == W_BOTTOM);

    always_comb begin
        color = C_BLACK;
        if (!active) begin
            color = C_BLACK;
        end else if (|hit_b) begin
            color = (|(hit_b & black_hl)) ? C_RED : C_BLACK;
        end else if (|hit_w) begin
            if (outline)                  color = C_BLACK;
            else if (|(hit_w & white_hl)) color = C_RED;
            else                          color = C_WHITE;
        end
    end

    p_one_white_rect_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_w));
    p_one_black_rect_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_b));
    p_black_inside_white_r7: assert property (@(posedge clk) disable iff (rst)
        (|hit_b) |-> (|hit_w));

endmodule

// File: rtl/piano_vga_top.sv
module piano_vga_top
    import piano_vga_pkg::*;
#(
    parameter int H_ACTIVE  = 640,
    parameter int H_FRONT   = 16,
    parameter int H_PULSE   = 96,
    parameter int H_BACK    = 48,
    parameter int V_ACTIVE  = 480,
    parameter int V_FRONT   = 10,
    parameter int V_PULSE   = 2,
    parameter int V_BACK    = 33,
    parameter int NUM_WHITE = 14,
    parameter int KB_X      = 40,
    parameter int KB_Y      = 300,
    parameter int WHITE_W   = 40,
    parameter int WHITE_H   = 160,
    parameter int BLACK_W   = 24,
    parameter int BLACK_H   = 100,
    localparam int KEY_W    = $clog2(2 * NUM_WHITE)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             key_valid,
    input  logic [KEY_W-1:0] key_idx,
    input  logic             key_clear,
    output logic             hsync_n,
    output logic             vsync_n,
    output logic             red,
    output logic             green,
    output logic             blue
);
    logic                 pix_en;
    scan_t                scan;
    logic [NUM_WHITE-1:0] white_hl;
    logic [NUM_WHITE-2:0] black_hl;
    rgb_t                 color;
    rgb_t                 color_q;

    vga_scan #(
        .H_ACTIVE(H_ACTIVE), .H_FRONT(H_FRONT), .H_PULSE(H_PULSE), .H_BACK(H_BACK),
        .V_ACTIVE(V_ACTIVE), .V_FRONT(V_FRONT), .V_PULSE(V_PULSE), .V_BACK(V_BACK)
    ) u_scan (
        .clk    (clk),
        .rst    (rst),
        .pix_en (pix_en),
        .scan   (scan)
    );

    key_select #(
        .NUM_WHITE(NUM_WHITE), .KEY_W(KEY_W)
    ) u_select (
        .clk        (clk),
        .rst        (rst),
        .key_valid  (key_valid),
        .key_idx    (key_idx),
        .key_clear  (key_clear),
        .frame_load (pix_en && scan.frame_start),
        .white_hl   (white_hl),
        .black_hl   (black_hl)
    );

    key_painter #(
        .NUM_WHITE(NUM_WHITE), .KB_X(KB_X), .KB_Y(KB_Y),
        .WHITE_W(WHITE_W), .WHITE_H(WHITE_H), .BLACK_W(BLACK_W), .BLACK_H(BLACK_H)
    ) u_painter (
        .clk      (clk),
        .rst      (rst),
        .px       (scan.x),
        .py       (scan.y),
        .active   (scan.active),
        .white_hl (white_hl),
        .black_hl (black_hl),
        .color    (color)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            hsync_n <= 1'b1;
            vsync_n <= 1'b1;
            color_q <= C_BLACK;
        end else if (pix_en) begin
            hsync_n <= scan.hs_n;
            vsync_n <= scan.vs_n;
            color_q <= color;
        end
    end

    assign red   = color_q.r;
    assign green = color_q.g;
    assign blue  = color_q.b;

    p_blank_outside_r4: assert property (@(posedge clk) disable iff (rst)
        (pix_en && !scan.active) |=> ({red, green, blue} == 3'b000));
    p_outputs_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !pix_en |=> ($stable(hsync_n) && $stable(vsync_n) && $stable({red, green, blue})));
    p_no_color_in_sync_r1: assert property (@(posedge clk) disable iff (rst)
        (!hsync_n || !vsync_n) |-> ({red, green, blue} == 3'b000));

endmodule

// File: tb/piano_vga_top_test.sv
module piano_vga_top_test;

    localparam int HA = 40, HF = 2, HP = 4, HB = 2;
    localparam int VA = 20, VF = 1, VP = 2, VB = 1;
    localparam int NW = 7, X0 = 2, Y0 = 3, WW = 5, WH = 14, BW = 3, BH = 8;
    localparam int KW = $clog2(2 * NW);
    localparam int HT = HA + HF + HP + HB;
    localparam int VT = VA + VF + VP + VB;
    localparam int FT = HT * VT;
    localparam int REQ_PIX  = 5 * HT + 10;
    localparam int LOAD_PIX = (VA + VF) * HT;
    localparam int FRAMES   = 11;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          key_valid = 1'b0;
    logic [KW-1:0] key_idx = '0;
    logic          key_clear = 1'b0;
    logic          hsync_n, vsync_n, red, green, blue;

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 1'b0;

    always #2 clk = ~clk;

    piano_vga_top #(
        .H_ACTIVE(HA), .H_FRONT(HF), .H_PULSE(HP), .H_BACK(HB),
        .V_ACTIVE(VA), .V_FRONT(VF), .V_PULSE(VP), .V_BACK(VB),
        .NUM_WHITE(NW), .KB_X(X0), .KB_Y(Y0), .WHITE_W(WW), .WHITE_H(WH),
        .BLACK_W(BW), .BLACK_H(BH)
    ) uut (
        .clk(clk), .rst(rst), .key_valid(key_valid), .key_idx(key_idx),
        .key_clear(key_clear), .hsync_n(hsync_n), .vsync_n(vsync_n),
        .red(red), .green(green), .blue(blue)
    );

    task automatic chk(input bit ok, input string req, input int pix, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s pixel %0d: actual %0d expected %0d", req, pix, act, exp);
        end
    endtask

    // R9 index rule
    function automatic bit idx_ok(input int idx);
        int j;
        if (idx < NW) return 1'b1;
        j = idx - NW;
        return (j <= NW - 2) && (j % 7 != 2) && (j % 7 != 6);
    endfunction

    // Expected colour from R4..R8; tag names the governing requirement
    function automatic int exp_rgb(input int h, input int v, input bit hv, input int hi, output string tag);
        int xr, j, i;
        if (h >= HA || v >= VA) begin tag = "R4"; return 0; end
        if (v >= Y0 && v < Y0 + BH) begin
            xr = h - X0 + BW / 2;
            if (xr >= WW) begin
                j = xr / WW - 1;
                if ((xr % WW) < BW && j <= NW - 2 && j % 7 != 2 && j % 7 != 6) begin
                    if (hv && hi == NW + j) begin tag = "R8"; return 4; end
                    tag = "R7"; return 0;
                end
            end
        end
        if (v >= Y0 && v < Y0 + WH && h >= X0 && h < X0 + NW * WW) begin
            i = (h - X0) / WW;
            if ((h - X0) % WW == 0 || h == X0 + NW * WW - 1 || v == Y0 || v == Y0 + WH - 1) begin
                tag = "R6"; return 0;
            end
            if (hv && hi == i) begin tag = "R8"; return 4; end
            tag = "R6"; return 7;
        end
        tag = "R5";
        return 0;
    endfunction

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        int    c;
        int    n, f, h, v, e;
        bit    pend_v, cur_v;
        int    pend_i, cur_i;
        string tag;
        string scen [FRAMES] = '{"R3", "R11", "R8", "R8", "R9", "R8", "R10", "R8", "R10", "R8", "R9"};
        pend_v = 0; cur_v = 0; pend_i = 0; cur_i = 0; c = 0;

        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(hsync_n === 1'b1 && vsync_n === 1'b1, "R3 reset sync", -1, {hsync_n, vsync_n}, 3);
        chk({red, green, blue} === 3'b000, "R3 reset rgb", -1, {red, green, blue}, 0);
        rst = 1'b0;
        @(posedge clk); c = 1;
        @(negedge clk);
        chk(hsync_n === 1'b1 && {red, green, blue} === 3'b000, "R3 first edge hold", -1,
            {hsync_n, red, green, blue}, 8);

        while (c < 2 * FRAMES * FT + 2) begin
            @(posedge clk); c++;
            @(negedge clk);
            key_valid = 1'b0;
            key_clear = 1'b0;
            if (c % 2 == 0) begin
                n = c / 2 - 1;
                f = n / FT;
                h = n % HT;
                v = (n / HT) % VT;
                chk(hsync_n === !(h >= HA + HF && h < HA + HF + HP), "R1 hsync", n, hsync_n,
                    !(h >= HA + HF && h < HA + HF + HP));
                chk(vsync_n === !(v >= VA + VF && v < VA + VF + VP), "R2 vsync", n, vsync_n,
                    !(v >= VA + VF && v < VA + VF + VP));
                e = exp_rgb(h, v, cur_v, cur_i, tag);
                chk({red, green, blue} === 3'(e), {tag, " rgb, frame scenario ", scen[f]}, n,
                    {red, green, blue}, e);
                if (n % FT == REQ_PIX) begin
                    case (f)
                        1: begin key_valid = 1'b1; key_idx = 4'd2;  end
                        2: begin key_valid = 1'b1; key_idx = 4'd8;  end
                        3: begin key_valid = 1'b1; key_idx = 4'd9;  end
                        4: begin key_valid = 1'b1; key_idx = 4'd11; end
                        5: begin key_clear = 1'b1; end
                        6: begin key_valid = 1'b1; key_idx = 4'd6;  end
                        7: begin key_valid = 1'b1; key_idx = 4'd0; key_clear = 1'b1; end
                        8: begin key_valid = 1'b1; key_idx = 4'd0;  end
                        9: begin key_valid = 1'b1; key_idx = 4'd13; end
                        default: ;
                    endcase
                    if (key_clear) pend_v = 1'b0;
                    else if (key_valid) begin pend_v = idx_ok(int'(key_idx)); pend_i = int'(key_idx); end
                end
                if (n % FT == LOAD_PIX) begin
                    cur_v = pend_v;
                    cur_i = pend_i;
                end
            end
        end
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (2 * FRAMES * FT + 20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule